// File: doc/BRIEF.md
# Eight-Pin GPIO Port Register Block with Bit-Masked Writes

This block holds the control state for one port of eight general-purpose pins. A simple memory-mapped bus reaches it. Three writable registers set each pin's behaviour:

- a select register that chooses between GPIO use and the pin's alternate function;
- a drive-enable register;
- a drive-value register.

A fourth, read-only register shows the pad levels after they pass through a two-flop synchronizer. The three writable registers drive the pad-side outputs directly.

Each writable register has two addresses. The normal address takes a whole-register write. A second, aliased address sits 0x800 above it. A write to the alias carries a per-pin write mask in bits 15:8 and the new pin values in bits 7:0. Software can therefore change one pin atomically, with no read-modify-write sequence and no lock.

The block decodes addresses within a bank window. Bit 11 selects the alias. Bits 5:4 select the register. Bits 3:2 must match the port slot given by a parameter.

Top module: `gpio_port_regs`

## Requirements
- R1: After a synchronous active-low reset, the select, drive-enable and drive-value registers are all zero, so every pin is an input, and `bus_rdata` is zero.
- R2: A write with bit 11 clear replaces all eight bits of the addressed register with `bus_wdata[7:0]`. The new value appears on the matching pad output (`pin_gpio_sel`, `pad_oe`, `pad_out`) at the clock edge that takes the write.
- R3: A write with bit 11 set changes only the bits whose mask bit `bus_wdata[8+i]` is 1. Each such bit i takes `bus_wdata[i]`. All other bits keep their value.
- R4: An aliased write whose mask byte is zero leaves the addressed register unchanged.
- R5: A read returns, in `bus_rdata[7:0]`, the contents of the addressed register at the edge that takes the read. The data is valid from that edge until the next edge, and `bus_rdata[15:8]` is always zero.
- R6: A read at an aliased address (bit 11 set) returns the same data as the normal address of the same register.
- R7: The input register (register field 3) holds the pad levels after two flops. A read issued in the cycle of a pad change returns the old level. A read issued two cycles later returns the new level.
- R8: The input register is read-only. A write to it, at either address, changes no register and no pad output.
- R9: An address is mapped only if all of these hold: bits 10:6 are zero, bits 3:2 equal `PORT_SEL`, and bits 1:0 are zero. The register field is bits 5:4, coded 0 select, 1 drive-enable, 2 drive-value, 3 input. A write to an unmapped address changes nothing, and a read there returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 12 | Byte address within the bank window |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 16 | Write data: mask in 15:8 at the alias, values in 7:0 |
| bus_rdata | output | 16 | Registered read data |
| pad_in | input | 8 | Asynchronous pad levels |
| pad_out | output | 8 | Drive value per pin |
| pad_oe | output | 8 | Drive enable per pin |
| pin_gpio_sel | output | 8 | 1 = pin used as GPIO, 0 = alternate function |

## Verification
- **Writes:** a write or masked write is due on the pad outputs one edge after the strobe. The bench drives each access at a falling edge and compares the pads at the next falling edge.
- **Reads:** read data is registered, so it is also due one edge after the strobe, and it is sampled at that same falling edge.
- **Pad inputs:** a pad change needs two edges to reach the input register and a third to reach `bus_rdata`. The bench issues three back-to-back reads after a pad change and expects old, old, then new.
- **Random accesses:** during the random accesses the pads are held constant, so the expected input value is never in flight.

// File: rtl/gpio_port_pkg.sv
// Shared types for the GPIO port register block.
// Assumes the register field of the address is two bits wide.
package gpio_port_pkg;

    // Register field codes; the order is the address decode order.
    typedef enum logic [1:0] {
        REG_SEL  = 2'd0,
        REG_OE   = 2'd1,
        REG_OUT  = 2'd2,
        REG_IN   = 2'd3
    } reg_sel_e;

    // Decoded access: mapped flag, alias flag and register field.
    typedef struct packed {
        logic     hit;
        logic     masked;
        reg_sel_e sel;
    } dec_t;

endpackage

// File: rtl/gpio_addr_dec.sv
// Address decoder for one port slot in a bank window.
// The top bit of the address picks the masked alias, and bits 5:4 pick the register.
// Bits 3:2 must equal PORT_SEL. Bits 1:0 and all bits between bit 6 and the
// alias bit must be zero. Assumes ADDR_W >= 8.
module gpio_addr_dec
    import gpio_port_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int PORT_SEL = 0
) (
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);
    localparam int ALIAS_BIT = ADDR_W - 1;

    // Pure combinational decode of the incoming address.
    always_comb begin
        dec.masked = addr[ALIAS_BIT];
        dec.sel    = reg_sel_e'(addr[5:4]);
        dec.hit    = (addr[ALIAS_BIT-1:6] == '0) &&
                     (addr[3:2] == 2'(PORT_SEL)) &&
                     (addr[1:0] == 2'b00);
    end
endmodule

// File: rtl/gpio_mask_reg.sv
// One writable per-pin register with whole and bit-masked write.
// A whole write loads the low W bits of wdata. A masked write loads only the
// bits whose mask bit (wdata[W+i]) is set. Assumes wr is already decoded.
module gpio_mask_reg #(
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr,
    input  logic           masked,
    input  logic [2*W-1:0] wdata,
    output logic [W-1:0]   q
);
    logic [W-1:0] mask;
    logic [W-1:0] val;
    logic [W-1:0] nxt;

    // Split the write data and merge the masked value with the held state.
    always_comb begin
        mask = wdata[2*W-1:W];
        val  = wdata[W-1:0];
        nxt  = masked ? ((q & ~mask) | (val & mask)) : val;
    end

    // Register state with synchronous reset to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (wr) q <= nxt;
    end

    AST_WHOLE_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !masked) |=> (q == $past(val)));                            // R2
    AST_MASK_KEEPS_CLEAR_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && masked) |=> (((q ^ $past(q)) & ~$past(mask)) == '0));       // R3
    AST_MASK_SETS_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && masked) |=> ((q & $past(mask)) == ($past(val) & $past(mask)))); // R3
    AST_ZERO_MASK_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && masked && (mask == '0)) |=> $stable(q));                    // R4
endmodule

// File: rtl/gpio_in_sync.sv
// Two-flop synchronizer for the asynchronous pad inputs.
// The second stage is the architectural input register.
module gpio_in_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    // Shift the pad levels through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/gpio_port_regs.sv
// Register block for one eight-pin GPIO port.
// Holds select, drive-enable and drive-value registers, each with a normal and
// a bit-masked write address, plus a synchronized read-only input register.
// Assumes single-cycle bus strobes and at most one of bus_wr or bus_rd per cycle.
module gpio_port_regs
    import gpio_port_pkg::*;
#(
    parameter int PINS     = 8,
    parameter int ADDR_W   = 12,
    parameter int PORT_SEL = 0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [2*PINS-1:0]  bus_wdata,
    output logic [2*PINS-1:0]  bus_rdata,
    input  logic [PINS-1:0]    pad_in,
    output logic [PINS-1:0]    pad_out,
    output logic [PINS-1:0]    pad_oe,
    output logic [PINS-1:0]    pin_gpio_sel
);
    localparam int N_WREG = 3;
    localparam int DATA_W = 2 * PINS;

    dec_t            dec;
    logic [PINS-1:0] wreg_q [N_WREG];
    logic [PINS-1:0] in_q;
    logic [PINS-1:0] rd_mux;

    gpio_addr_dec #(.ADDR_W(ADDR_W), .PORT_SEL(PORT_SEL)) i_dec (
        .addr (bus_addr),
        .dec  (dec)
    );

    // One masked register per writable register field.
    for (genvar g = 0; g < N_WREG; g++) begin : g_wreg
        logic wr_g;
        assign wr_g = bus_wr && dec.hit && (dec.sel == reg_sel_e'(2'(g)));
        gpio_mask_reg #(.W(PINS)) i_reg (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr     (wr_g),
            .masked (dec.masked),
            .wdata  (bus_wdata),
            .q      (wreg_q[g])
        );
    end

    gpio_in_sync #(.W(PINS)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .q     (in_q)
    );

    // Route register state to the pad side.
    assign pin_gpio_sel = wreg_q[REG_SEL];
    assign pad_oe       = wreg_q[REG_OE];
    assign pad_out      = wreg_q[REG_OUT];

    // Select the read source by register field.
    always_comb begin
        unique case (dec.sel)
            REG_SEL: rd_mux = wreg_q[REG_SEL];
            REG_OE:  rd_mux = wreg_q[REG_OE];
            REG_OUT: rd_mux = wreg_q[REG_OUT];
            default: rd_mux = in_q;
        endcase
    end

    // Register read data; zero when no mapped read is taking place.
    always_ff @(posedge clk) begin
        if (!rst_n)                 bus_rdata <= '0;
        else if (bus_rd && dec.hit) bus_rdata <= {{(DATA_W-PINS){1'b0}}, rd_mux};
        else                        bus_rdata <= '0;
    end

    AST_RDATA_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[DATA_W-1:PINS] == '0);                                   // R5
    AST_INPUT_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && dec.hit && dec.sel == REG_IN) |=>
        ($stable(pad_out) && $stable(pad_oe) && $stable(pin_gpio_sel)));   // R8
    AST_UNMAPPED_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !dec.hit) |=>
        ($stable(pad_out) && $stable(pad_oe) && $stable(pin_gpio_sel)));   // R9
    AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !dec.hit) |=> (bus_rdata == '0));                       // R9
endmodule

// File: tb/test_gpio_port_regs.sv
module test_gpio_port_regs;
    localparam int PINS = 8;
    localparam int PORT = 1;

    logic        clk = 0;
    logic        rst_n;
    logic [11:0] bus_addr;
    logic        bus_wr, bus_rd;
    logic [15:0] bus_wdata;
    logic [15:0] bus_rdata;
    logic [7:0]  pad_in, pad_out, pad_oe, pin_gpio_sel;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] m_reg [3];

    gpio_port_regs #(.PINS(PINS), .ADDR_W(12), .PORT_SEL(PORT)) i_gpio_port_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .pin_gpio_sel(pin_gpio_sel)
    );

    always #5 clk = ~clk;

    function automatic logic mapped(input logic [11:0] a);
        return (a[10:6] == 5'd0) && (a[3:2] == 2'(PORT)) && (a[1:0] == 2'd0);
    endfunction

    function automatic logic [7:0] merge(input logic [7:0] old, input logic [15:0] d,
                                         input logic msk);
        return msk ? ((old & ~d[15:8]) | (d[7:0] & d[15:8])) : d[7:0];
    endfunction

    function automatic logic [11:0] mk_addr(input int field, input logic alias_b);
        return {alias_b, 5'd0, 2'(field), 2'(PORT), 2'b00};
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_pads(input string req);
        check(req, {8'd0, pin_gpio_sel}, {8'd0, m_reg[0]});
        check(req, {8'd0, pad_oe},       {8'd0, m_reg[1]});
        check(req, {8'd0, pad_out},      {8'd0, m_reg[2]});
    endtask

    // Caller is at a falling edge; result is sampled at the next falling edge.
    task automatic access(input logic [11:0] a, input logic w, input logic r,
                          input logic [15:0] d);
        bus_addr = a; bus_wr = w; bus_rd = r; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0; bus_rd = 0;
        if (w && mapped(a) && a[5:4] != 2'd3)
            m_reg[a[5:4]] = merge(m_reg[a[5:4]], d, a[11]);
    endtask

    function automatic logic [15:0] exp_read(input logic [11:0] a);
        if (!mapped(a)) return 16'd0;
        if (a[5:4] == 2'd3) return {8'd0, pad_in};
        return {8'd0, m_reg[a[5:4]]};
    endfunction

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd1234));
        for (int i = 0; i < 3; i++) m_reg[i] = 8'd0;
        rst_n = 0; bus_addr = 0; bus_wr = 0; bus_rd = 0; bus_wdata = 0; pad_in = 8'h00;
        repeat (4) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        check_pads("R1");
        check("R1", bus_rdata, 16'd0);

        // R2 whole write to each register
        for (int f = 0; f < 3; f++) begin
            access(mk_addr(f, 0), 1, 0, 16'hFF00 | 16'(8'hA5 + f));
            check_pads("R2");
        end
        // R3 masked write on drive value
        access(mk_addr(2, 1), 1, 0, 16'h0F_F0);
        check_pads("R3");
        check("R3", {8'd0, pad_out}, 16'h00A7 & 16'h00F0 | 16'h00A7 & 16'h00F0 ? {8'd0, (8'hA7 & 8'hF0)} : 16'd0);
        // R4 masked write with zero mask
        access(mk_addr(1, 1), 1, 0, 16'h00_5A);
        check("R4", {8'd0, pad_oe}, 16'h00A6);
        // R5 read, R6 alias read
        access(mk_addr(0, 0), 0, 1, 16'd0);
        check("R5", bus_rdata, 16'h00A5);
        access(mk_addr(0, 1), 0, 1, 16'd0);
        check("R6", bus_rdata, 16'h00A5);
        // R8 write to input register at both addresses
        access(mk_addr(3, 0), 1, 0, 16'hFFFF);
        check_pads("R8");
        access(mk_addr(3, 1), 1, 0, 16'hFFFF);
        check_pads("R8");
        // R9 other port slot, stray bits
        access(mk_addr(2, 0) ^ 12'h004, 1, 0, 16'h0033);
        check_pads("R9");
        access(mk_addr(2, 0) | 12'h040, 1, 0, 16'h0033);
        check_pads("R9");
        access(mk_addr(2, 0) | 12'h001, 0, 1, 16'd0);
        check("R9", bus_rdata, 16'd0);

        // R7 synchronizer latency: old, old, new
        pad_in = 8'h3C;
        access(mk_addr(3, 0), 0, 1, 16'd0);
        check("R7", bus_rdata, 16'h0000);
        access(mk_addr(3, 0), 0, 1, 16'd0);
        check("R7", bus_rdata, 16'h0000);
        access(mk_addr(3, 1), 0, 1, 16'd0);
        check("R7", bus_rdata, 16'h003C);

        // Random mix of R2 R3 R5 R6 R8 R9 accesses
        for (int k = 0; k < 400; k++) begin
            logic [11:0] a;
            logic [15:0] d;
            logic        w;
            logic [15:0] e;
            a = mk_addr(int'($urandom_range(0, 3)), 1'($urandom_range(0, 1)));
            case ($urandom_range(0, 7))
                0: a[3:2] = 2'($urandom);
                1: a[10:6] = 5'($urandom);
                2: a[1:0] = 2'($urandom);
                default: ;
            endcase
            d = 16'($urandom);
            w = 1'($urandom_range(0, 1));
            e = exp_read(a);
            access(a, w, !w, d);
            if (w) check_pads("R3 random write");
            else   check("R5 random read", bus_rdata, e);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule